// File: doc/BRIEF.md
# FMA special-operand resolver

This combinational block sits in front of a single-precision fused multiply-add unit that computes d = z + x*y. It looks at the raw encodings of the multiplicands x and y and the addend z, sorts each one into a class (zero, subnormal, normal, infinity, quiet NaN, signalling NaN), and decides whether the special cases already fix the result.

When a special case decides the outcome, the block raises a bypass-valid flag and drives the final result word, along with an invalid-operation flag where one applies. When every operand is an ordinary finite value and the product is nonzero, it raises a proceed flag instead, and the arithmetic datapath then produces the result.

NaN priority is fixed and asymmetric. An addend signalling NaN is checked first. After that come x, then y, and the addend's quiet NaN is looked at only after the product operands. An infinite product also overrides an infinite addend without raising invalid, even when the two infinities have opposite signs.

Top module: `fma_special_resolve`

## Requirements
- R1: Each operand is classified from its bits. Exponent 0 with fraction 0 is zero. Exponent 0 with a nonzero fraction is subnormal. An exponent of all ones with fraction 0 is infinity. An exponent of all ones with a nonzero fraction is a NaN: it is quiet when fraction bit 22 is 1 and signalling otherwise. Every other value is normal. The sign is bit 31 and the exponent is bits 30:23.
- R2: A signalling-NaN addend raises invalid_o and returns the addend with fraction bit 22 set and its sign and payload kept. This holds whatever x and y are.
- R3: When the addend is not a signalling NaN and x is a signalling NaN, the block returns the quieted x and raises invalid_o. This holds even when y is also a signalling NaN.
- R4: When y is a signalling NaN and neither the addend nor x is, the block returns the quieted y and raises invalid_o.
- R5: When no operand is a signalling NaN, a quiet NaN in x is returned unchanged. Otherwise a quiet NaN in y is returned unchanged. Both rules win over a quiet-NaN addend, and neither raises invalid_o.
- R6: Infinity times zero, in either order, returns a quiet-NaN addend unchanged. Otherwise it raises invalid_o and returns the default NaN 32'h7FC00000.
- R7: Infinity times a nonzero finite value or infinity returns a quiet-NaN addend unchanged. Otherwise it returns an infinity whose sign is sign(x) XOR sign(y). An infinite addend of either sign is ignored and invalid_o stays low.
- R8: Zero times a zero or finite value returns an infinity with the addend's sign when the addend is infinite. Otherwise it returns the addend word unchanged.
- R9: When both multiplicands are subnormal or normal, a quiet-NaN addend is returned unchanged and an infinite addend returns an infinity with its sign. Any other addend sets proceed_o and clears bypass_vld_o.
- R10: Exactly one of bypass_vld_o and proceed_o is high. While proceed_o is high, bypass_res_o is zero and invalid_o is low.
- R11: The flags depend only on the current operands. invalid_o is low for a clean operation that directly follows one which raised it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_i | input | 32 | Multiplicand x, single-precision encoding |
| y_i | input | 32 | Multiplicand y, single-precision encoding |
| z_i | input | 32 | Addend z, single-precision encoding |
| bypass_vld_o | output | 1 | Result is fixed by a special case |
| bypass_res_o | output | 32 | Special-case result word, zero when not bypassing |
| invalid_o | output | 1 | Invalid-operation exception for this operation |
| proceed_o | output | 1 | Operands go to the arithmetic datapath |

## Verification
The assertions assume the inputs are stable, fully known 32-bit words evaluated with the default parameters. Under those parameters a set fraction bit 22 marks a quiet NaN and the default NaN is itself quiet. The stimulus respects this by driving inputs only between sampling points, never with X values, and only from per-class representative encodings, each of which decodes unambiguously to one class. A sweep over all 216 class combinations, run with two sign patterns, exercises every branch of the priority chain under these same conditions.

// File: rtl/fma_sp_pkg.sv
package fma_sp_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_QNAN = 3'd4,
    CLS_SNAN = 3'd5
  } fma_cls_e;

  function automatic logic cls_is_fin_nz(fma_cls_e c);
    return (c == CLS_SUB) || (c == CLS_NORM);
  endfunction
endpackage

// File: rtl/fma_op_class.sv
module fma_op_class
  import fma_sp_pkg::*;
#(
  parameter int   EXP_W     = 8,
  parameter int   FRAC_W    = 23,
  parameter logic QUIET_POL = 1'b1
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output fma_cls_e              cls_o,
  output logic                  sign_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  exp_w;
  logic [FRAC_W-1:0] frac_w;

  assign sign_o = op_i[W-1];
  assign exp_w  = op_i[W-2:FRAC_W];
  assign frac_w = op_i[FRAC_W-1:0];

  always_comb begin
    if (exp_w == '0)
      cls_o = (frac_w == '0) ? CLS_ZERO : CLS_SUB;
    else if (exp_w == '1) begin
      if (frac_w == '0)                        cls_o = CLS_INF;
      else if (frac_w[FRAC_W-1] == QUIET_POL)  cls_o = CLS_QNAN;
      else                                     cls_o = CLS_SNAN;
    end else
      cls_o = CLS_NORM;
  end
endmodule

// File: rtl/fma_nan_quiet.sv
module fma_nan_quiet #(
  parameter int                   EXP_W      = 8,
  parameter int                   FRAC_W     = 23,
  parameter logic                 QUIET_POL  = 1'b1,
  parameter bit                   QUIET_DFLT = 1'b0,
  parameter logic [EXP_W+FRAC_W:0] DFLT_NAN  = 'h7FC0_0000
) (
  input  logic [EXP_W+FRAC_W:0] op_i,
  output logic [EXP_W+FRAC_W:0] quiet_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic [FRAC_W-1:0] frac_q;

  always_comb begin
    frac_q = op_i[FRAC_W-1:0];
    frac_q[FRAC_W-1] = QUIET_POL;
    // clearing the flag bit may leave an empty payload: keep it a NaN
    if (frac_q == '0) frac_q[FRAC_W-2] = 1'b1;
  end

  if (QUIET_DFLT) begin : g_dflt
    assign quiet_o = DFLT_NAN;
  end else begin : g_keep
    assign quiet_o = {op_i[W-1:FRAC_W], frac_q};
  end
endmodule

// File: rtl/fma_special_pick.sv
module fma_special_pick
  import fma_sp_pkg::*;
#(
  parameter int                    EXP_W    = 8,
  parameter int                    FRAC_W   = 23,
  parameter logic [EXP_W+FRAC_W:0] DFLT_NAN = 'h7FC0_0000
) (
  input  fma_cls_e              cls_x_i,
  input  fma_cls_e              cls_y_i,
  input  fma_cls_e              cls_z_i,
  input  logic                  sgn_x_i,
  input  logic                  sgn_y_i,
  input  logic                  sgn_z_i,
  input  logic [EXP_W+FRAC_W:0] raw_x_i,
  input  logic [EXP_W+FRAC_W:0] raw_y_i,
  input  logic [EXP_W+FRAC_W:0] raw_z_i,
  input  logic [EXP_W+FRAC_W:0] qt_x_i,
  input  logic [EXP_W+FRAC_W:0] qt_y_i,
  input  logic [EXP_W+FRAC_W:0] qt_z_i,
  output logic                  byp_o,
  output logic [EXP_W+FRAC_W:0] res_o,
  output logic                  inv_o,
  output logic                  go_o
);
  function automatic logic [EXP_W+FRAC_W:0] inf_w(logic s);
    return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  endfunction

  logic inf_zero, prod_inf, prod_zero;

  assign inf_zero  = (cls_x_i == CLS_INF  && cls_y_i == CLS_ZERO) ||
                     (cls_x_i == CLS_ZERO && cls_y_i == CLS_INF);
  assign prod_inf  = (cls_x_i == CLS_INF)  || (cls_y_i == CLS_INF);
  assign prod_zero = (cls_x_i == CLS_ZERO) || (cls_y_i == CLS_ZERO);

  // fixed chain: z sNaN, x sNaN, y sNaN, x qNaN, y qNaN, then product classes
  always_comb begin
    byp_o = 1'b1;
    res_o = '0;
    inv_o = 1'b0;
    go_o  = 1'b0;
    if (cls_z_i == CLS_SNAN) begin
      inv_o = 1'b1;
      res_o = qt_z_i;
    end else if (cls_x_i == CLS_SNAN) begin
      inv_o = 1'b1;
      res_o = qt_x_i;
    end else if (cls_y_i == CLS_SNAN) begin
      inv_o = 1'b1;
      res_o = qt_y_i;
    end else if (cls_x_i == CLS_QNAN) begin
      res_o = raw_x_i;
    end else if (cls_y_i == CLS_QNAN) begin
      res_o = raw_y_i;
    end else if (inf_zero) begin
      if (cls_z_i == CLS_QNAN) res_o = raw_z_i;
      else begin
        inv_o = 1'b1;
        res_o = DFLT_NAN;
      end
    end else if (prod_inf) begin
      res_o = (cls_z_i == CLS_QNAN) ? raw_z_i : inf_w(sgn_x_i ^ sgn_y_i);
    end else if (prod_zero) begin
      res_o = (cls_z_i == CLS_INF) ? inf_w(sgn_z_i) : raw_z_i;
    end else if (cls_z_i == CLS_QNAN) begin
      res_o = raw_z_i;
    end else if (cls_z_i == CLS_INF) begin
      res_o = inf_w(sgn_z_i);
    end else begin
      byp_o = 1'b0;
      go_o  = 1'b1;
    end
  end
endmodule

// File: rtl/fma_special_resolve.sv
module fma_special_resolve
  import fma_sp_pkg::*;
#(
  parameter int                    EXP_W      = 8,
  parameter int                    FRAC_W     = 23,
  parameter logic                  QUIET_POL  = 1'b1,
  parameter bit                    QUIET_DFLT = 1'b0,
  parameter logic [EXP_W+FRAC_W:0] DFLT_NAN   = 'h7FC0_0000
) (
  input  logic [EXP_W+FRAC_W:0] x_i,
  input  logic [EXP_W+FRAC_W:0] y_i,
  input  logic [EXP_W+FRAC_W:0] z_i,
  output logic                  bypass_vld_o,
  output logic [EXP_W+FRAC_W:0] bypass_res_o,
  output logic                  invalid_o,
  output logic                  proceed_o
);
  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int N_OPS = 3;

  logic [W-1:0] op_w  [N_OPS];
  logic [W-1:0] qt_w  [N_OPS];
  fma_cls_e     cls_w [N_OPS];
  logic         sgn_w [N_OPS];

  assign op_w[0] = x_i;
  assign op_w[1] = y_i;
  assign op_w[2] = z_i;

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    fma_op_class #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .QUIET_POL(QUIET_POL)
    ) u_cls (
      .op_i(op_w[g]), .cls_o(cls_w[g]), .sign_o(sgn_w[g])
    );
    fma_nan_quiet #(
      .EXP_W(EXP_W), .FRAC_W(FRAC_W), .QUIET_POL(QUIET_POL),
      .QUIET_DFLT(QUIET_DFLT), .DFLT_NAN(DFLT_NAN)
    ) u_qt (
      .op_i(op_w[g]), .quiet_o(qt_w[g])
    );
  end

  fma_special_pick #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .DFLT_NAN(DFLT_NAN)
  ) u_pick (
    .cls_x_i(cls_w[0]), .cls_y_i(cls_w[1]), .cls_z_i(cls_w[2]),
    .sgn_x_i(sgn_w[0]), .sgn_y_i(sgn_w[1]), .sgn_z_i(sgn_w[2]),
    .raw_x_i(x_i),      .raw_y_i(y_i),      .raw_z_i(z_i),
    .qt_x_i(qt_w[0]),   .qt_y_i(qt_w[1]),   .qt_z_i(qt_w[2]),
    .byp_o(bypass_vld_o), .res_o(bypass_res_o),
    .inv_o(invalid_o),    .go_o(proceed_o)
  );
endmodule

// File: rtl/fma_special_chk.sv
module fma_special_chk #(
  parameter int   EXP_W     = 8,
  parameter int   FRAC_W    = 23,
  parameter logic QUIET_POL = 1'b1
) (
  input logic [EXP_W+FRAC_W:0] x_i,
  input logic [EXP_W+FRAC_W:0] y_i,
  input logic [EXP_W+FRAC_W:0] z_i,
  input logic                  bypass_vld_o,
  input logic [EXP_W+FRAC_W:0] bypass_res_o,
  input logic                  invalid_o,
  input logic                  proceed_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  function automatic logic is_nan(logic [W-1:0] v);
    return (v[W-2:FRAC_W] == '1) && (v[FRAC_W-1:0] != '0);
  endfunction
  function automatic logic is_snan(logic [W-1:0] v);
    return is_nan(v) && (v[FRAC_W-1] != QUIET_POL);
  endfunction
  function automatic logic is_spec(logic [W-1:0] v);
    return (v[W-2:FRAC_W] == '1) || (v[W-2:0] == '0);
  endfunction

  always_comb begin
    p_one_path_r10: assert (bypass_vld_o != proceed_o)
      else $error("bypass and proceed not exclusive");
    p_proceed_clean_r10: assert (!proceed_o || (bypass_res_o == '0 && !invalid_o))
      else $error("proceed with result or invalid");
    p_z_snan_r2: assert (!is_snan(z_i) || (invalid_o && bypass_vld_o &&
                         bypass_res_o[W-1] == z_i[W-1] && is_nan(bypass_res_o)))
      else $error("addend sNaN not flagged");
    p_any_snan_r3: assert (!(is_snan(x_i) || is_snan(y_i) || is_snan(z_i)) || invalid_o)
      else $error("sNaN without invalid");
    p_nan_out_quiet_r5: assert (!(bypass_vld_o && is_nan(bypass_res_o)) ||
                                (bypass_res_o[FRAC_W-1] == QUIET_POL))
      else $error("signalling NaN produced");
    p_proceed_ops_r9: assert (!proceed_o || !(is_spec(x_i) || is_spec(y_i) ||
                              z_i[W-2:FRAC_W] == '1))
      else $error("proceed with special operand");
  end
endmodule

bind fma_special_resolve fma_special_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .QUIET_POL(QUIET_POL)
) u_chk (
  .x_i(x_i), .y_i(y_i), .z_i(z_i),
  .bypass_vld_o(bypass_vld_o), .bypass_res_o(bypass_res_o),
  .invalid_o(invalid_o), .proceed_o(proceed_o)
);

// File: tb/sim_fma_special_resolve.sv
module sim_fma_special_resolve;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] x, y, z;
  logic        byp, inv, go;
  logic [31:0] res;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  fma_special_resolve u0 (
    .x_i(x), .y_i(y), .z_i(z),
    .bypass_vld_o(byp), .bypass_res_o(res),
    .invalid_o(inv), .proceed_o(go)
  );

  localparam logic [31:0] DNAN = 32'h7FC0_0000;

  // class ids: 0 zero, 1 sub, 2 norm, 3 inf, 4 qnan, 5 snan
  function automatic logic [31:0] mk(int c, bit s);
    case (c)
      0: return {s, 31'h0};
      1: return {s, 8'h00, 23'h000123};
      2: return {s, 8'h80, 23'h200000};
      3: return {s, 8'hFF, 23'h000000};
      4: return {s, 8'hFF, 23'h400055};
      default: return {s, 8'hFF, 23'h000ABC};
    endcase
  endfunction

  function automatic logic [31:0] inf_of(bit s);
    return {s, 8'hFF, 23'h0};
  endfunction

  task automatic chk(string tag, logic eb, logic ei, logic eg, logic [31:0] er);
    total++;
    if (byp !== eb || inv !== ei || go !== eg || res !== er) begin
      bad++;
      $display("FAIL %s: x=%h y=%h z=%h got byp=%b inv=%b go=%b res=%h exp byp=%b inv=%b go=%b res=%h",
               tag, x, y, z, byp, inv, go, res, eb, ei, eg, er);
    end
  endtask

  task automatic apply(logic [31:0] ax, logic [31:0] ay, logic [31:0] az);
    @(negedge clk);
    x = ax; y = ay; z = az;
    @(posedge clk);
    #1;
  endtask

  task automatic t_idle;
    apply(32'h0, 32'h0, 32'h0);
    chk("R8 idle", 1'b1, 1'b0, 1'b0, 32'h0);
  endtask

  task automatic t_z_snan_payload;
    apply(mk(4, 0), mk(5, 0), {1'b1, 8'hFF, 23'h000ABC});
    chk("R2 payload", 1'b1, 1'b1, 1'b0, 32'hFFC0_0ABC);
  endtask

  task automatic t_both_snan;
    apply({1'b0, 8'hFF, 23'h000111}, {1'b1, 8'hFF, 23'h000222}, mk(4, 0));
    chk("R3 both sNaN", 1'b1, 1'b1, 1'b0, 32'h7FC0_0111);
    apply(mk(2, 0), {1'b1, 8'hFF, 23'h000222}, mk(4, 0));
    chk("R4 y sNaN", 1'b1, 1'b1, 1'b0, 32'hFFC0_0222);
  endtask

  task automatic t_qnan_order;
    apply({1'b1, 8'hFF, 23'h400001}, {1'b0, 8'hFF, 23'h400002}, {1'b0, 8'hFF, 23'h400003});
    chk("R5 x over y", 1'b1, 1'b0, 1'b0, {1'b1, 8'hFF, 23'h400001});
    apply(mk(3, 0), {1'b0, 8'hFF, 23'h400002}, {1'b0, 8'hFF, 23'h400003});
    chk("R5 y over z", 1'b1, 1'b0, 1'b0, {1'b0, 8'hFF, 23'h400002});
  endtask

  task automatic t_inf_cancel;
    apply(mk(3, 0), mk(2, 0), mk(3, 1));
    chk("R7 inf minus inf", 1'b1, 1'b0, 1'b0, inf_of(1'b0));
    apply(mk(3, 1), mk(3, 0), mk(2, 0));
    chk("R7 sign xor", 1'b1, 1'b0, 1'b0, inf_of(1'b1));
  endtask

  task automatic t_flag_clear;
    apply(mk(0, 0), mk(3, 0), mk(2, 0));
    chk("R6 inf*0", 1'b1, 1'b1, 1'b0, DNAN);
    apply(mk(2, 0), mk(2, 1), mk(2, 0));
    chk("R11 flags cleared", 1'b0, 1'b0, 1'b1, 32'h0);
  endtask

  task automatic t_zero_sub;
    apply(mk(0, 1), mk(2, 0), {1'b1, 8'h00, 23'h000777});
    chk("R8 zero keeps z", 1'b1, 1'b0, 1'b0, {1'b1, 8'h00, 23'h000777});
  endtask

  function automatic string tag_of(int cx, int cy, int cz);
    if (cz == 5) return "R2";
    if (cx == 5) return "R3";
    if (cy == 5) return "R4";
    if (cx == 4 || cy == 4) return "R5";
    if ((cx == 3 && cy == 0) || (cx == 0 && cy == 3)) return "R6";
    if (cx == 3 || cy == 3) return "R7";
    if (cx == 0 || cy == 0) return "R8";
    if (cz == 0 || cz == 1 || cz == 2) return "R10";
    return "R9";
  endfunction

  task automatic t_sweep(bit pat);
    for (int cx = 0; cx < 6; cx++)
      for (int cy = 0; cy < 6; cy++)
        for (int cz = 0; cz < 6; cz++) begin
          bit sx = pat ^ cx[0];
          bit sy = pat ^ cy[1];
          bit sz = ~pat ^ cz[0];
          logic [31:0] wx = mk(cx, sx);
          logic [31:0] wy = mk(cy, sy);
          logic [31:0] wz = mk(cz, sz);
          logic eb = 1'b1;
          logic ei = 1'b0;
          logic eg = 1'b0;
          logic [31:0] er = 32'h0;
          if (cz == 5) begin ei = 1'b1; er = wz | 32'h0040_0000; end
          else if (cx == 5) begin ei = 1'b1; er = wx | 32'h0040_0000; end
          else if (cy == 5) begin ei = 1'b1; er = wy | 32'h0040_0000; end
          else if (cx == 4) er = wx;
          else if (cy == 4) er = wy;
          else if ((cx == 3 && cy == 0) || (cx == 0 && cy == 3)) begin
            if (cz == 4) er = wz; else begin ei = 1'b1; er = DNAN; end
          end else if (cx == 3 || cy == 3) er = (cz == 4) ? wz : inf_of(sx ^ sy);
          else if (cx == 0 || cy == 0) er = (cz == 3) ? inf_of(sz) : wz;
          else if (cz == 4) er = wz;
          else if (cz == 3) er = inf_of(sz);
          else begin eb = 1'b0; eg = 1'b1; end
          apply(wx, wy, wz);
          chk($sformatf("R1 sweep %s cls=%0d/%0d/%0d", tag_of(cx, cy, cz), cx, cy, cz),
              eb, ei, eg, er);
        end
  endtask

  initial begin
    x = '0; y = '0; z = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_z_snan_payload();
    t_both_snan();
    t_qnan_order();
    t_inf_cancel();
    t_flag_clear();
    t_zero_sub();
    t_sweep(1'b0);
    t_sweep(1'b1);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule